// File: doc/BRIEF.md
# Software Interrupt Register Bank

This block gives software a way to raise an inter-processor interrupt on any hart of a cluster. Each hart owns one 32-bit register in a small address window; storing a word whose least significant bit is one into a hart's register raises that hart's software-interrupt output. The window starts at a base address fixed at build time and is reached over a 32-bit register bus. That bus has a request channel and a read-response channel, and each channel uses a valid/ready handshake.

The `MODE` parameter is fixed at build time and selects one of two flavours. In machine flavour each hart has a stored pending bit. A store with bit 0 clear drops that bit, and a load returns it. In supervisor flavour the interrupt can only be set. Each set-store produces a single-cycle pulse on the output, because the receiving core keeps its own pending state. Stores of zero do nothing in this flavour, and loads always return zero.

Handshake rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is held and `rsp_ready` is low. Only reads produce a response. A response is held, unchanged, until `rsp_ready` is seen high.

Top module: `swi_bank`

## Requirements
- R1: The register of slot i is at byte address BASE_ADDR + 4*i. Only data bit 0 takes effect on a store. Bits 31:1 are ignored on stores and return zero on loads.
- R2: In either flavour, a taken store to slot i with bit 0 = 1 drives `sw_irq[i]` high on the first clock edge after the store is taken.
- R3: In machine flavour, a taken store to slot i with bit 0 = 0 drives `sw_irq[i]` low on the next edge. In machine flavour, `sw_irq[i]` changes only through stores to slot i.
- R4: In machine flavour, a taken load of slot i returns, on `rsp_rdata` bit 0, the pending bit as it stood when the load was taken.
- R5: In supervisor flavour, a store with bit 0 = 0 has no effect. An isolated set-store raises `sw_irq[i]` for exactly one cycle.
- R6: In supervisor flavour, every load returns zero.
- R7: The following addresses are decoded as invalid: a slot index at or beyond NUM_HARTS, an address below BASE_ADDR, and an address with non-zero bits 1:0. A load of an invalid address returns zero. A store to an invalid address changes no output.
- R8: After reset, all `sw_irq` bits are low, `rsp_valid` is low and `req_ready` is high.
- R9: Back-pressure works as follows. While `rsp_valid` is high and `rsp_ready` is low, the response data stays unchanged and `req_ready` is low, so a pending request is held and does not take effect until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data (bit 0 used) |
| rsp_valid | output | 1 | Load data present |
| rsp_ready | input | 1 | Consumer takes load data |
| rsp_rdata | output | 32 | Load data |
| sw_irq | output | NUM_HARTS | Per-hart software-interrupt outputs |

## Verification
The bench builds two copies side by side from the same stimulus, one in each flavour. Both use an 8-bit address, a base of 0x40 and three harts. Three harts is not a power of two, so the word at 0x4C still fits in the index field but must be rejected. The non-zero base makes the addresses below the window reachable. Running the flavours in lockstep lets a single store show a held bit in one copy and a one-cycle pulse in the other. A stalled response channel is also exercised while a store is queued behind it.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic {
    SWI_MACHINE = 1'b0,
    SWI_SUPER   = 1'b1
  } swi_mode_e;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int unsigned AW        = 12,
  parameter logic [AW-1:0] BASE_ADDR = '0,
  parameter int unsigned NUM_HARTS = 4,
  localparam int unsigned IDXW     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  logic [AW-1:0] offset;
  logic [AW-1:0] word;

  always_comb begin
    offset = addr - BASE_ADDR;
    word   = offset >> 2;
    hit    = (addr >= BASE_ADDR) && (offset[1:0] == 2'b00) && (word < AW'(NUM_HARTS));
    idx    = word[IDXW-1:0];
  end
endmodule

// File: rtl/swi_slot.sv
module swi_slot
  import swi_pkg::*;
#(
  parameter swi_mode_e MODE = SWI_MACHINE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wbit,
  output logic irq,
  output logic rd_bit
);
  logic state_q;

  generate
    if (MODE == SWI_MACHINE) begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= 1'b0;
        else if (wr_hit) state_q <= wbit;
      end
      assign rd_bit = state_q;

      // R3
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(irq));
      // R2
      set_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wbit) |=> irq);
    end else begin : g_pulse
      always_ff @(posedge clk) begin
        if (!rst_n) state_q <= 1'b0;
        else        state_q <= wr_hit && wbit;
      end
      assign rd_bit = 1'b0;

      // R5
      pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(wr_hit && wbit));
    end
  endgenerate

  assign irq = state_q;
endmodule

// File: rtl/swi_resp.sv
module swi_resp
  import swi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/swi_bank.sv
module swi_bank
  import swi_pkg::*;
#(
  parameter swi_mode_e     MODE      = SWI_MACHINE,
  parameter int unsigned   MAX_HARTS = 4095,
  parameter int unsigned   NUM_HARTS = 4,
  parameter int unsigned   AW        = 16,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] sw_irq
);
  localparam int unsigned IDXW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  initial begin
    cfg_chk: assert (BASE_ADDR[1:0] == 2'b00 && NUM_HARTS >= 1 && NUM_HARTS <= MAX_HARTS)
      else $error("swi_bank: bad configuration");
  end

  logic            take, wr_take, rd_take;
  logic            hit;
  logic [IDXW-1:0] idx;
  logic [NUM_HARTS-1:0] wr_sel;
  logic [NUM_HARTS-1:0] rd_bits;
  logic [DW-1:0]   rd_word;
  logic            unused_wdata;

  assign unused_wdata = ^req_wdata[31:1];
  assign req_ready    = !rsp_valid || rsp_ready;
  assign take         = req_valid && req_ready;
  assign wr_take      = take && req_write;
  assign rd_take      = take && !req_write;

  swi_decode #(
    .AW(AW), .BASE_ADDR(BASE_ADDR), .NUM_HARTS(NUM_HARTS)
  ) u_dec (
    .addr(req_addr), .hit(hit), .idx(idx)
  );

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_slot
    assign wr_sel[i] = wr_take && hit && (idx == IDXW'(i));
    swi_slot #(.MODE(MODE)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_sel[i]), .wbit(req_wdata[0]),
      .irq(sw_irq[i]), .rd_bit(rd_bits[i])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_HARTS; k++) begin
      if (hit && idx == IDXW'(k)) rd_word[0] = rd_bits[k];
    end
  end

  swi_resp u_rsp (
    .clk(clk), .rst_n(rst_n),
    .load(rd_take), .load_data(rd_word),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !hit) |=> (rsp_rdata == '0));
  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[31:1] == '0));
  // R7
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && !hit) |-> (wr_sel == '0));

  if (MODE == SWI_SUPER) begin : g_sup_chk
    // R6
    sup_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_rdata == '0));
  end
endmodule

// File: tb/tb_swi_bank.sv
module tb_swi_bank;
  import swi_pkg::*;

  localparam int unsigned AW = 8;
  localparam int unsigned NH = 3;
  localparam logic [AW-1:0] BASE = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rdy_m, rdy_s, vld_m, vld_s;
  logic [31:0] rd_m, rd_s;
  logic [NH-1:0] irq_m, irq_s;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_m[$];
  logic [31:0] exp_s[$];

  always #5 clk = ~clk;

  swi_bank #(.MODE(SWI_MACHINE), .NUM_HARTS(NH), .AW(AW), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_m),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(vld_m), .rsp_ready(rsp_ready), .rsp_rdata(rd_m), .sw_irq(irq_m));

  swi_bank #(.MODE(SWI_SUPER), .NUM_HARTS(NH), .AW(AW), .BASE_ADDR(BASE)) dut_sup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_s),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(vld_s), .rsp_ready(rsp_ready), .rsp_rdata(rd_s), .sw_irq(irq_s));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [31:0] em, input logic [31:0] es);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (!wr) begin exp_m.push_back(em); exp_s.push_back(es); end
    while (!(rdy_m && rdy_s)) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_ready) begin
      if (vld_m) begin
        if (exp_m.size() == 0) chk("R4 unexpected machine response", 32'h1, 32'h0);
        else chk("R4/R7 machine read", rd_m, exp_m.pop_front());
      end
      if (vld_s) begin
        if (exp_s.size() == 0) chk("R6 unexpected supervisor response", 32'h1, 32'h0);
        else chk("R6/R7 supervisor read", rd_s, exp_s.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 irq machine", 32'(irq_m), 32'h0);
    chk("R8 irq supervisor", 32'(irq_s), 32'h0);
    chk("R8 rsp_valid", {30'h0, vld_m, vld_s}, 32'h0);
    chk("R8 req_ready", {30'h0, rdy_m, rdy_s}, 32'h3);

    // R2 set slot 0
    send(1'b1, 8'h40, 32'h1, 0, 0);
    @(negedge clk);
    chk("R2 machine set slot0", 32'(irq_m), 32'h1);
    chk("R2 supervisor pulse high", 32'(irq_s), 32'h1);
    @(negedge clk);
    chk("R5 supervisor pulse one cycle", 32'(irq_s), 32'h0);
    chk("R3 machine level held", 32'(irq_m), 32'h1);

    // R1 upper bits ignored, slot 2
    send(1'b1, 8'h48, 32'hFFFF_FFFF, 0, 0);
    @(negedge clk);
    chk("R1 machine slot2 set", 32'(irq_m), 32'h5);
    send(1'b0, 8'h48, 0, 32'h1, 32'h0);      // R4 R6 R1
    send(1'b0, 8'h44, 0, 32'h0, 32'h0);

    // R3 clear with upper bits set, bit0 clear
    send(1'b1, 8'h40, 32'hFFFF_FFFE, 0, 0);
    @(negedge clk);
    chk("R3 machine slot0 cleared", 32'(irq_m), 32'h4);
    chk("R5 supervisor zero-store no pulse", 32'(irq_s), 32'h0);
    send(1'b0, 8'h40, 0, 32'h0, 32'h0);

    // R7 invalid stores: beyond last slot, misaligned, below base
    send(1'b1, 8'h4C, 32'h1, 0, 0);
    @(negedge clk);
    chk("R7 out-of-range store machine", 32'(irq_m), 32'h4);
    chk("R7 out-of-range store supervisor", 32'(irq_s), 32'h0);
    send(1'b1, 8'h42, 32'h1, 0, 0);
    @(negedge clk);
    chk("R7 misaligned store machine", 32'(irq_m), 32'h4);
    chk("R7 misaligned store supervisor", 32'(irq_s), 32'h0);
    send(1'b1, 8'h3C, 32'h1, 0, 0);
    @(negedge clk);
    chk("R7 below-base store machine", 32'(irq_m), 32'h4);
    chk("R7 below-base store supervisor", 32'(irq_s), 32'h0);
    send(1'b0, 8'h4A, 0, 32'h0, 32'h0);
    send(1'b0, 8'h4C, 0, 32'h0, 32'h0);

    // set slot 1
    send(1'b1, 8'h44, 32'h1, 0, 0);
    @(negedge clk);
    chk("R2 machine slot1 set", 32'(irq_m), 32'h6);
    chk("R2 supervisor slot1 pulse", 32'(irq_s), 32'h2);

    // R9 back-pressure
    rsp_ready = 1'b0;
    send(1'b0, 8'h48, 0, 32'h1, 32'h0);
    @(negedge clk);
    chk("R9 response held valid", {30'h0, vld_m, vld_s}, 32'h3);
    chk("R9 req_ready low while stalled", {30'h0, rdy_m, rdy_s}, 32'h0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h44; req_wdata = 32'h0;
    @(negedge clk);
    chk("R9 queued store not applied", 32'(irq_m), 32'h6);
    chk("R9 data stable", rd_m, 32'h1);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk("R9 queued store applied after release", 32'(irq_m), 32'h4);
    repeat (2) @(negedge clk);
    chk("R4 all responses consumed", 32'(exp_m.size() + exp_s.size()), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule